// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block receives asynchronous serial frames on a single line. A baud tick, supplied from outside at 8 or 16 times the bit rate, paces the block. Each bit is decided by a 2-of-3 vote of samples taken around its centre, so a single corrupted sample does not change the result. A frame has one low start bit and eight data bits, least significant first. An optional ninth bit marks address words in multidrop mode, an optional parity bit follows, and a stop bit ends the frame.

The received word sits in a one-word holding register with a valid strobe. Framing, parity and overrun flags travel with the word. A separate break flag reports a line held low for a whole frame. A single-cycle read acknowledge frees the holding register and clears all flags. In multidrop mode the block compares address words with a programmed station address. It passes data words only while the most recent address word matched.

Top module: `uart_vote_rx`

## Requirements
- R1: With `osr16`=1 a bit lasts 16 baud ticks; with `osr16`=0 it lasts 8. Phases are counted from the tick on which the synchronised line is first seen low, which is phase 0.
- R2: Each bit value is the majority of the three line samples taken on the ticks at phases H-1, H and H+1 of that bit, where H is half the bit length in ticks. A single flipped sample does not change the bit.
- R3: A start bit whose voted value is high is discarded, and the receiver returns to idle with no word delivered.
- R4: The frame is start, 8 data bits LSB first, then a ninth bit only when `addrMode`=1, then a parity bit only when `parEn`=1, then the stop bit. `rxValid` rises one clock after the tick that decides the stop bit, and `rxData` holds the data bits at that time.
- R5: With `parEn`=1, `parityErr` is set on a delivered word when the XOR of the data bits, the ninth bit and the parity bit is not equal to `parOdd` (0 = even, 1 = odd).
- R6: `frameErr` is set on a delivered word whose voted stop bit is low.
- R7: `overrunErr` is set when a word is delivered while `rxValid` is still high and `rdAck` is not asserted in that cycle. The new word replaces the old one.
- R8: When every voted bit of a frame is low, stop bit included, `breakDet` is set and no word is delivered. The receiver ignores the line until it is sampled high on a tick.
- R9: With `addrMode`=1, a word whose ninth bit is 1 is an address. It is delivered with `rxIsAddr`=1 only if its data bits equal `myAddr`, and a match enables the delivery of the following data words (ninth bit 0). Data words that arrive before any match are dropped.
- R10: An address word that does not match `myAddr` is dropped and disables the delivery of data words until the next matching address.
- R11: `rdAck` clears `rxValid`, `frameErr`, `parityErr`, `overrunErr` and `breakDet`, unless a new word or a break is recorded in the same cycle. `breakDet` otherwise stays set.
- R12: After reset, `rxValid`, all flags, `rxIsAddr` and `rxData` are zero, and no address match is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Serial line, idle high |
| baudTick | input | 1 | One-cycle pulse at the oversampling rate |
| osr16 | input | 1 | 1: 16 ticks per bit, 0: 8 ticks per bit |
| parEn | input | 1 | Parity bit present |
| parOdd | input | 1 | 1: odd parity, 0: even parity |
| addrMode | input | 1 | Enables the ninth bit and address filtering |
| myAddr | input | DATA_W | Station address |
| rdAck | input | 1 | Acknowledges the held word and flags |
| rxData | output | DATA_W | Received data bits |
| rxValid | output | 1 | Word held and not yet acknowledged |
| rxIsAddr | output | 1 | Held word is a matching address |
| frameErr | output | 1 | Stop bit of the held word was low |
| parityErr | output | 1 | Parity of the held word was wrong |
| overrunErr | output | 1 | Held word overwrote an unacknowledged one |
| breakDet | output | 1 | Break seen since the last acknowledge |

## Verification
The assertions assume that `baudTick` is a single-cycle pulse. They also assume that `osr16`, `parEn`, `parOdd`, `addrMode` and `myAddr` stay constant while a frame is in flight, so that an address delivery can be compared with the current `myAddr`. The stimulus changes configuration only while the line has idled high for at least two bit times. It pulses `rdAck` for one clock at a time, and it spaces ticks four clocks apart. Frames are driven with whole-bit timing, except for deliberate one-tick glitches that hit a single vote sample or a start bit.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP,
    RX_HOLD
  } rxPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;     // shift current line value into the vote window
    logic clrFrame;   // start of a new frame
    logic writeBit;   // store voted bit at bitIdx
    logic deliver;    // load holding register
    logic stopLow;    // voted stop bit was low
    logic markBreak;  // record break
    logic setMatch;   // matching address seen
    logic clrMatch;   // non-matching address seen
  } rxStb_t;

endpackage

// File: rtl/uvr_ctrl.sv
module uvr_ctrl
  import uvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR_HI = 16,
  localparam int PH_W  = $clog2(OSR_HI),
  localparam int IDX_W = $clog2(DATA_W + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             line,
  input  logic             osr16,
  input  logic             parEn,
  input  logic             addrMode,
  input  logic             voteNow,
  input  logic             frameZero,
  input  logic             ninthBit,
  input  logic             addrHit,
  input  logic             matched,
  output rxStb_t           stb,
  output logic [IDX_W-1:0] bitIdx
);

  localparam logic [IDX_W-1:0] LAST_D    = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] NINTH_IDX = IDX_W'(DATA_W);
  localparam logic [IDX_W-1:0] PAR_IDX   = IDX_W'(DATA_W + 1);

  rxPhase_e         st;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  half;
  logic [PH_W-1:0]  lastPh;
  logic             inWin;
  logic             decide;
  logic             isAddr;

  assign half   = osr16 ? PH_W'(OSR_HI / 2) : PH_W'(OSR_HI / 4);
  assign lastPh = osr16 ? PH_W'(OSR_HI - 1) : PH_W'(OSR_HI / 2 - 1);
  assign inWin  = (phase == half - 1'b1) || (phase == half) || (phase == half + 1'b1);
  assign decide = (phase == half + 1'b1);
  assign isAddr = addrMode && ninthBit;

  always_comb begin
    stb = '0;
    if (baudTick) begin
      if (st inside {RX_START, RX_BITS, RX_STOP} && inWin) stb.sample = 1'b1;
      if (st == RX_IDLE && !line) stb.clrFrame = 1'b1;
      if (st == RX_BITS && decide) stb.writeBit = 1'b1;
      if (st == RX_STOP && decide) begin
        if (!voteNow && frameZero) begin
          stb.markBreak = 1'b1;
        end else begin
          stb.deliver  = !addrMode || (isAddr ? addrHit : matched);
          stb.stopLow  = !voteNow;
          stb.setMatch = isAddr && addrHit;
          stb.clrMatch = isAddr && !addrHit;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= RX_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (baudTick) begin
      case (st)
        RX_IDLE: begin
          if (!line) begin
            st    <= RX_START;
            phase <= PH_W'(1);
          end
        end
        RX_START: begin
          if (decide && voteNow) begin
            st <= RX_IDLE;
          end else if (phase == lastPh) begin
            st     <= RX_BITS;
            phase  <= '0;
            bitIdx <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        RX_BITS: begin
          if (phase == lastPh) begin
            phase <= '0;
            if (bitIdx == LAST_D) begin
              if (addrMode)   bitIdx <= NINTH_IDX;
              else if (parEn) bitIdx <= PAR_IDX;
              else            st     <= RX_STOP;
            end else if (bitIdx == NINTH_IDX) begin
              if (parEn) bitIdx <= PAR_IDX;
              else       st     <= RX_STOP;
            end else if (bitIdx == PAR_IDX) begin
              st <= RX_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        RX_STOP: begin
          if (decide) st <= stb.markBreak ? RX_HOLD : RX_IDLE;
          else        phase <= phase + 1'b1;
        end
        RX_HOLD: begin
          if (line) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uvr_dpath.sv
module uvr_dpath
  import uvr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W   = $clog2(DATA_W + 2),
  localparam int FRAME_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  rxStb_t            stb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] myAddr,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              addrMode,
  input  logic              rdAck,
  output logic              line,
  output logic              voteNow,
  output logic              frameZero,
  output logic              ninthBit,
  output logic              addrHit,
  output logic              matched,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsAddr,
  output logic              frameErr,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              breakDet
);

  logic               syncA, syncB;
  logic [1:0]         votes;
  logic [FRAME_W-1:0] frame;
  logic               parBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= rxIn;
      syncB <= syncA;
    end
  end
  assign line = syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           votes <= 2'b11;
    else if (stb.sample) votes <= {votes[0], line};
  end
  assign voteNow = (votes[1] & votes[0]) | (votes[1] & line) | (votes[0] & line);

  for (genvar i = 0; i < FRAME_W; i++) begin : g_frame
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          frame[i] <= 1'b0;
      else if (stb.clrFrame)                              frame[i] <= 1'b0;
      else if (stb.writeBit && bitIdx == IDX_W'(i))       frame[i] <= voteNow;
    end
  end

  assign frameZero = ~|frame;
  assign ninthBit  = frame[DATA_W];
  assign addrHit   = (frame[DATA_W-1:0] == myAddr);
  assign parBad    = parEn && ((^frame) != parOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             matched <= 1'b0;
    else if (stb.setMatch) matched <= 1'b1;
    else if (stb.clrMatch) matched <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxIsAddr   <= 1'b0;
      frameErr   <= 1'b0;
      parityErr  <= 1'b0;
      overrunErr <= 1'b0;
      breakDet   <= 1'b0;
    end else begin
      if (rdAck) begin
        rxValid    <= 1'b0;
        frameErr   <= 1'b0;
        parityErr  <= 1'b0;
        overrunErr <= 1'b0;
        breakDet   <= 1'b0;
      end
      if (stb.deliver) begin
        rxData     <= frame[DATA_W-1:0];
        rxIsAddr   <= addrMode && ninthBit;
        frameErr   <= stb.stopLow;
        parityErr  <= parBad;
        overrunErr <= rxValid && !rdAck;
        rxValid    <= 1'b1;
      end
      if (stb.markBreak) breakDet <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR_HI = 16,
  localparam int IDX_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic              baudTick,
  input  logic              osr16,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              addrMode,
  input  logic [DATA_W-1:0] myAddr,
  input  logic              rdAck,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsAddr,
  output logic              frameErr,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              breakDet
);

  rxStb_t           stb;
  logic [IDX_W-1:0] bitIdx;
  logic             line, voteNow, frameZero, ninthBit, addrHit, matched;

  uvr_ctrl #(.DATA_W(DATA_W), .OSR_HI(OSR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .line(line),
    .osr16(osr16), .parEn(parEn), .addrMode(addrMode),
    .voteNow(voteNow), .frameZero(frameZero), .ninthBit(ninthBit),
    .addrHit(addrHit), .matched(matched), .stb(stb), .bitIdx(bitIdx)
  );

  uvr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .stb(stb), .bitIdx(bitIdx),
    .myAddr(myAddr), .parEn(parEn), .parOdd(parOdd), .addrMode(addrMode),
    .rdAck(rdAck), .line(line), .voteNow(voteNow), .frameZero(frameZero),
    .ninthBit(ninthBit), .addrHit(addrHit), .matched(matched),
    .rxData(rxData), .rxValid(rxValid), .rxIsAddr(rxIsAddr),
    .frameErr(frameErr), .parityErr(parityErr), .overrunErr(overrunErr),
    .breakDet(breakDet)
  );

endmodule

// File: rtl/uvr_chk.sv
module uvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              baudTick,
  input logic              rdAck,
  input logic              deliverStb,
  input logic              rxValid,
  input logic              rxIsAddr,
  input logic [DATA_W-1:0] rxData,
  input logic [DATA_W-1:0] myAddr,
  input logic              overrunErr,
  input logic              breakDet
);

  // R4
  word_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(baudTick));

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(rxValid));

  // R8
  break_no_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDet) |-> !$rose(rxValid));

  // R9
  addr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxValid) && rxIsAddr) |-> (rxData == myAddr));

  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAck && !deliverStb) |=> !rxValid);

  // R11
  break_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (breakDet && !rdAck) |=> breakDet);

endmodule

bind uart_vote_rx uvr_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .rdAck(rdAck),
  .deliverStb(stb.deliver), .rxValid(rxValid), .rxIsAddr(rxIsAddr),
  .rxData(rxData), .myAddr(myAddr), .overrunErr(overrunErr),
  .breakDet(breakDet)
);

// File: tb/uart_vote_rx_test.sv
module uart_vote_rx_test;

  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick = 1'b0;
  logic       osr16 = 1'b1, parEn = 1'b0, parOdd = 1'b0, addrMode = 1'b0;
  logic [7:0] myAddr = 8'h00;
  logic       rdAck = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, rxIsAddr, frameErr, parityErr, overrunErr, breakDet;

  int total = 0, fails = 0, tcnt = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  uart_vote_rx uut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick), .osr16(osr16),
    .parEn(parEn), .parOdd(parOdd), .addrMode(addrMode), .myAddr(myAddr),
    .rdAck(rdAck), .rxData(rxData), .rxValid(rxValid), .rxIsAddr(rxIsAddr),
    .frameErr(frameErr), .parityErr(parityErr), .overrunErr(overrunErr),
    .breakDet(breakDet)
  );

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % TDIV;
    baudTick = (tcnt == 0);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   mSt, mPh, mFld, h, osrN;
  bit   m1, m2, mLine, v, dlv, brkNow, oldValid, isA, hit, allz, px, mMatch;
  bit   mb[10];
  int   sq[$];
  logic [7:0] eData, wData;
  bit   eValid, eIsA, eFe, ePe, eOv, eBrk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 = 1; m2 = 1; mSt = 0; mPh = 0; mFld = -1; mMatch = 0; sq.delete();
      eData = 0; eValid = 0; eIsA = 0; eFe = 0; ePe = 0; eOv = 0; eBrk = 0;
      started = 1;
    end else begin
      mLine = m2; m2 = m1; m1 = rxIn;
      dlv = 0; brkNow = 0;
      if (baudTick) begin
        h = osr16 ? 8 : 4;
        osrN = 2 * h;
        if (mSt == 0) begin
          if (!mLine) begin
            mSt = 1; mPh = 1; mFld = -1; sq.delete();
            for (int i = 0; i < 10; i++) mb[i] = 0;
          end
        end else if (mSt == 2) begin
          if (mLine) mSt = 0;
        end else begin
          if (mPh >= h - 1 && mPh <= h + 1) sq.push_back(int'(mLine));
          if (mPh == h + 1) begin
            v = (sq[0] + sq[1] + sq[2]) >= 2;
            sq.delete();
            if (mFld == -1) begin
              if (v) mSt = 0;
            end else if (mFld < 10) begin
              mb[mFld] = v;
            end else begin
              allz = 1;
              for (int i = 0; i < 10; i++) if (mb[i]) allz = 0;
              if (!v && allz) begin
                brkNow = 1; mSt = 2;
              end else begin
                for (int i = 0; i < 8; i++) wData[i] = mb[i];
                isA = addrMode && mb[8];
                hit = (wData == myAddr);
                dlv = !addrMode || (isA ? hit : mMatch);
                if (isA) mMatch = hit;
                px = 0;
                for (int i = 0; i < 10; i++) px ^= mb[i];
                mSt = 0;
              end
            end
          end
          if (mSt == 1) begin
            if (mPh == osrN - 1) begin
              mPh = 0;
              if (mFld == -1) mFld = 0;
              else if (mFld < 7) mFld++;
              else if (mFld == 7) mFld = addrMode ? 8 : (parEn ? 9 : 10);
              else if (mFld == 8) mFld = parEn ? 9 : 10;
              else mFld = 10;
            end else mPh++;
          end
        end
      end
      oldValid = eValid;
      if (rdAck) begin
        eValid = 0; eFe = 0; ePe = 0; eOv = 0; eBrk = 0;
      end
      if (dlv) begin
        eData = wData; eIsA = isA; eFe = !v; ePe = parEn && (px != parOdd);
        eOv = oldValid && !rdAck; eValid = 1;
      end
      if (brkNow) eBrk = 1;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("R4 rxValid", rxValid, eValid);
      check("R4 rxData", rxData, eData);
      check("R9 rxIsAddr", rxIsAddr, eIsA);
      check("R6 frameErr", frameErr, eFe);
      check("R5 parityErr", parityErr, ePe);
      check("R7 overrunErr", overrunErr, eOv);
      check("R8 breakDet", breakDet, eBrk);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic int bitClk();
    return (osr16 ? 16 : 8) * TDIV;
  endfunction

  task automatic driveBit(input bit val, input bit glitch);
    int bp = bitClk();
    if (!glitch) begin
      rxIn = val;
      repeat (bp) @(negedge clk);
    end else begin
      rxIn = val;  repeat (bp / 2 - 2) @(negedge clk);
      rxIn = ~val; repeat (TDIV) @(negedge clk);
      rxIn = val;  repeat (bp - bp / 2 - 2) @(negedge clk);
    end
  endtask

  // glitchPos: position in the frame (0 = start) carrying a one-tick glitch, -1 none
  task automatic sendFrame(input logic [7:0] d, input bit ninth, input bit parVal,
                           input bit stopVal, input int glitchPos);
    int pos = 0;
    driveBit(1'b0, glitchPos == pos); pos++;
    for (int i = 0; i < 8; i++) begin driveBit(d[i], glitchPos == pos); pos++; end
    if (addrMode) begin driveBit(ninth, 1'b0); pos++; end
    if (parEn) driveBit(parVal, 1'b0);
    driveBit(stopVal, 1'b0);
    rxIn = 1'b1;
    repeat (2 * bitClk()) @(negedge clk);
  endtask

  function automatic bit goodPar(input logic [7:0] d, input bit ninth);
    bit p = ^d ^ (addrMode ? ninth : 1'b0);
    return parOdd ? ~p : p;
  endfunction

  task automatic ack();
    rdAck = 1'b1; @(negedge clk);
    rdAck = 1'b0; @(negedge clk);
  endtask

  task automatic expectWord(input string tag, input logic [7:0] d, input bit fe,
                            input bit pe, input bit ov);
    check({tag, " valid"}, rxValid, 1);
    check({tag, " data"}, rxData, d);
    check({tag, " frameErr"}, frameErr, fe);
    check({tag, " parityErr"}, parityErr, pe);
    check({tag, " overrunErr"}, overrunErr, ov);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 rxValid", rxValid, 0);
    check("R12 flags", {frameErr, parityErr, overrunErr, breakDet, rxIsAddr}, 0);
    rstN = 1'b1;
    repeat (40) @(negedge clk);

    // R1/R4 16x plain frame
    osr16 = 1; sendFrame(8'hA5, 0, 0, 1, -1);
    expectWord("R1 R4 16x", 8'hA5, 0, 0, 0); ack();
    check("R11 ack clears", rxValid, 0);

    // R1 8x frame
    osr16 = 0; repeat (40) @(negedge clk);
    sendFrame(8'h3C, 0, 0, 1, -1);
    expectWord("R1 8x", 8'h3C, 0, 0, 0); ack();

    // R2 single-sample glitch inside a data bit, both ratios
    sendFrame(8'hFF, 0, 0, 1, 4);
    expectWord("R2 8x vote", 8'hFF, 0, 0, 0); ack();
    osr16 = 1; repeat (80) @(negedge clk);
    sendFrame(8'h00 | 8'h5A, 0, 0, 1, 3);
    expectWord("R2 16x vote", 8'h5A, 0, 0, 0); ack();

    // R3 short low pulse is rejected as a start bit
    rxIn = 0; repeat (TDIV) @(negedge clk);
    rxIn = 1; repeat (3 * bitClk()) @(negedge clk);
    check("R3 no word after glitch", rxValid, 0);

    // R5 parity even correct, then odd wrong
    parEn = 1; parOdd = 0; repeat (40) @(negedge clk);
    sendFrame(8'h07, 0, goodPar(8'h07, 0), 1, -1);
    expectWord("R5 even ok", 8'h07, 0, 0, 0); ack();
    parOdd = 1; repeat (40) @(negedge clk);
    sendFrame(8'h07, 0, ~goodPar(8'h07, 0), 1, -1);
    expectWord("R5 odd bad", 8'h07, 0, 1, 0); ack();
    parEn = 0; parOdd = 0; repeat (40) @(negedge clk);

    // R6 framing error
    sendFrame(8'h81, 0, 0, 0, -1);
    expectWord("R6 stop low", 8'h81, 1, 0, 0); ack();

    // R7 overrun
    sendFrame(8'h11, 0, 0, 1, -1);
    sendFrame(8'h22, 0, 0, 1, -1);
    expectWord("R7 overrun", 8'h22, 0, 0, 1); ack();
    check("R7 cleared", overrunErr, 0);

    // R8 break, R11 sticky and cleared by ack
    rxIn = 0; repeat (12 * bitClk()) @(negedge clk);
    rxIn = 1; repeat (2 * bitClk()) @(negedge clk);
    check("R8 break flag", breakDet, 1);
    check("R8 no word", rxValid, 0);
    ack();
    check("R11 break cleared", breakDet, 0);
    sendFrame(8'h99, 0, 0, 1, -1);
    expectWord("R8 resumes", 8'h99, 0, 0, 0); ack();

    // R9 / R10 address filtering, with parity in the frame too
    addrMode = 1; myAddr = 8'h42; parEn = 1; repeat (40) @(negedge clk);
    sendFrame(8'h11, 0, goodPar(8'h11, 0), 1, -1);
    check("R9 data before match dropped", rxValid, 0);
    sendFrame(8'h42, 1, goodPar(8'h42, 1), 1, -1);
    expectWord("R9 addr", 8'h42, 0, 0, 0);
    check("R9 isAddr", rxIsAddr, 1); ack();
    sendFrame(8'h33, 0, goodPar(8'h33, 0), 1, -1);
    expectWord("R9 data after match", 8'h33, 0, 0, 0);
    check("R9 data isAddr", rxIsAddr, 0); ack();
    sendFrame(8'h55, 1, goodPar(8'h55, 1), 1, -1);
    check("R10 other addr dropped", rxValid, 0);
    sendFrame(8'h66, 0, goodPar(8'h66, 0), 1, -1);
    check("R10 data after mismatch dropped", rxValid, 0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule